// File: doc/BRIEF.md
# Serial PHY Tuning Write Sequencer

This block writes a tuning value of up to eight bits into the internal tuning space of one of several USB PHYs. All of the PHYs share a single 32-bit control register. A request names the target PHY, a start address, a data word and a bit count. The sequencer then sends the value one bit per strobe pulse. Data goes out LSB first, and the address advances by one for every bit. Each PHY has its own strobe lane in the control register.

For every bit the register is updated in four steps, always in the same order. First the address field is loaded. Next the data bit is set up and the lane's strobe is held low. Then the strobe is raised, and finally it is lowered again. Each step holds the register for a configurable number of clock cycles, so the PHY side sees levels that stay still between updates. A request flag selects the newer register layout. In that layout the entire register is cleared before the first bit is sent.

A valid/ready handshake accepts the requests. Once the last strobe has been lowered, a single-cycle done pulse is raised.

Top module: `phy_tune_sequencer`

## Requirements
- R1: After reset the control register reads 0, `req_ready` is 1 and `done` is 0.
- R2: `req_ready` is high only when the block is idle. A request is taken only on a cycle where both `req_valid` and `req_ready` are high. While a sequence runs, requests are refused and have no effect on the register writes.
- R3: When `req_zero_first` is 1 and the length is not zero, the whole 32-bit register is written to 0 before the first address is loaded.
- R4: For bit i, the address field in bits [15:8] is replaced by (start address + i) modulo 256. Bits outside the field keep their values.
- R5: The data bit sits in bit 7. Bit i of the data word is sent as bit i, so bit 0 goes first.
- R6: The strobe for PHY n is bit 2n. For each bit the register steps are taken in this order: load the address; write the data bit and clear the strobe; set the strobe; clear the strobe. No other strobe lane ever changes.
- R7: Each step lasts PHASE_CYCLES clock cycles, counting the clear-to-zero step. `done` goes high PHASE_CYCLES × (steps) cycles after the accepting clock edge.
- R8: A request with length 0 raises `done` on the next cycle and leaves the register unchanged.
- R9: A length above 8 is treated as 8.
- R10: `done` stays high for exactly one cycle for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block is idle and takes a request |
| req_phy | input | 2 | Index of the target PHY |
| req_addr | input | 8 | Tuning address of the first bit |
| req_data | input | 8 | Value to send, LSB first |
| req_len | input | 4 | Number of bits, clamped to 8 |
| req_zero_first | input | 1 | Clear the whole register before sending (newer layout) |
| done | output | 1 | One-cycle pulse when the request ends |
| ctrl_reg | output | 32 | The shared control register |

## Verification
Two cases are hard to reach from the ports. The first is a request offered while a sequence is already running. The stimulus holds `req_valid` high with unrelated fields for several cycles in the middle of a multi-bit write, and the scoreboard must then see exactly the writes of the original request and nothing else. The second is a zero-first request issued while the register still carries an address and data bit left by an earlier write. Without that leftover, the clearing step would change nothing and could not be seen, so the stimulus arranges the leftover first to make the clear observable.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ZERO,
        PH_ADDR,
        PH_DATA,
        PH_SET,
        PH_REL,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/tune_phase_timer.sv
module tune_phase_timer #(
    parameter int PHASE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic first,
    output logic last
);
    localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(PHASE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (restart) begin
            t_d.cnt = '0;
        end else if (t_q.cnt != LAST_CNT) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{cnt: LAST_CNT};
        else        t_q <= t_d;
    end

    assign first = (t_q.cnt == '0);
    assign last  = (t_q.cnt == LAST_CNT);

endmodule

// File: rtl/tune_seq_fsm.sv
module tune_seq_fsm
    import phy_tune_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_phy,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_zero_first,
    input  logic              phase_last,
    output phase_e            phase,
    output logic              restart,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_bit,
    output logic [IDX_W-1:0]  cur_phy
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DATA_W);

    typedef struct packed {
        phase_e            st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  left;
        logic [IDX_W-1:0]  phy;
    } seq_t;

    seq_t s_d, s_q;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        s_d     = s_q;
        eff_len = (req_len > MAX_LEN) ? MAX_LEN : req_len;
        unique case (s_q.st)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.addr = req_addr;
                    s_d.data = req_data;
                    s_d.left = eff_len;
                    s_d.phy  = req_phy;
                    if (eff_len == '0)      s_d.st = PH_DONE;
                    else if (req_zero_first) s_d.st = PH_ZERO;
                    else                    s_d.st = PH_ADDR;
                end
            end
            PH_ZERO: if (phase_last) s_d.st = PH_ADDR;
            PH_ADDR: if (phase_last) s_d.st = PH_DATA;
            PH_DATA: if (phase_last) s_d.st = PH_SET;
            PH_SET:  if (phase_last) s_d.st = PH_REL;
            PH_REL: begin
                if (phase_last) begin
                    if (s_q.left == LEN_W'(1)) begin
                        s_d.st = PH_DONE;
                    end else begin
                        s_d.st   = PH_ADDR;
                        s_d.left = s_q.left - 1'b1;
                        s_d.addr = s_q.addr + 1'b1;
                        s_d.data = s_q.data >> 1;
                    end
                end
            end
            PH_DONE: s_d.st = PH_IDLE;
            default: s_d.st = PH_IDLE;
        endcase
        restart = (s_d.st != s_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign phase    = s_q.st;
    assign cur_addr = s_q.addr;
    assign cur_bit  = s_q.data[0];
    assign cur_phy  = s_q.phy;

    // The bit count never runs out while a bit is still being sent.
    assert_left_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st inside {PH_ADDR, PH_DATA, PH_SET, PH_REL}) |-> (s_q.left != '0));

endmodule

// File: rtl/tune_ctrl_reg.sv
module tune_ctrl_reg
    import phy_tune_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int NUM_PHYS = 4,
    parameter int ADDR_W   = 8,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              phase_first,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_bit,
    input  logic [IDX_W-1:0]  cur_phy,
    output logic [REG_W-1:0]  ctrl
);
    localparam int DATA_POS = 7;
    localparam int ADDR_LSB = 8;
    localparam int ADDR_MSB = ADDR_LSB + ADDR_W - 1;
    localparam int POS_W    = $clog2(REG_W);

    typedef struct packed {
        logic [REG_W-1:0] val;
    } reg_t;

    reg_t r_d, r_q;
    logic [POS_W-1:0] lane_pos;
    logic [NUM_PHYS-1:0] strobes;

    always_comb begin
        r_d      = r_q;
        lane_pos = POS_W'(cur_phy) << 1;
        if (phase_first) begin
            unique case (phase)
                PH_ZERO: r_d.val = '0;
                PH_ADDR: r_d.val[ADDR_MSB:ADDR_LSB] = cur_addr;
                PH_DATA: begin
                    r_d.val[DATA_POS] = cur_bit;
                    r_d.val[lane_pos] = 1'b0;
                end
                PH_SET:  r_d.val[lane_pos] = 1'b1;
                PH_REL:  r_d.val[lane_pos] = 1'b0;
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl = r_q.val;

    for (genvar g = 0; g < NUM_PHYS; g++) begin : g_lane
        assign strobes[g] = r_q.val[2*g];
    end

    assert_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    assert_strobe_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|strobes) |-> $stable(r_q.val[ADDR_MSB:DATA_POS]));

    assert_strobe_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|strobes) |-> $stable(r_q.val[ADDR_MSB:DATA_POS]));

endmodule

// File: rtl/phy_tune_sequencer.sv
module phy_tune_sequencer
    import phy_tune_pkg::*;
#(
    parameter int NUM_PHYS     = 4,
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int REG_W        = 32,
    parameter int PHASE_CYCLES = 2,
    parameter int IDX_W        = $clog2(NUM_PHYS),
    parameter int LEN_W        = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDX_W-1:0]  req_phy,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_zero_first,
    output logic              done,
    output logic [REG_W-1:0]  ctrl_reg
);
    phase_e            phase;
    logic              restart;
    logic              ph_first;
    logic              ph_last;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_bit;
    logic [IDX_W-1:0]  cur_phy;

    tune_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_phy(req_phy), .req_addr(req_addr),
        .req_data(req_data), .req_len(req_len), .req_zero_first(req_zero_first),
        .phase_last(ph_last), .phase(phase), .restart(restart),
        .cur_addr(cur_addr), .cur_bit(cur_bit), .cur_phy(cur_phy)
    );

    tune_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .first(ph_first), .last(ph_last)
    );

    tune_ctrl_reg #(
        .REG_W(REG_W), .NUM_PHYS(NUM_PHYS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .phase(phase), .phase_first(ph_first),
        .cur_addr(cur_addr), .cur_bit(cur_bit), .cur_phy(cur_phy),
        .ctrl(ctrl_reg)
    );

    assign req_ready = (phase == PH_IDLE);
    assign done      = (phase == PH_DONE);

    assert_busy_refuse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_len_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == '0) |=> (done && $stable(ctrl_reg)));

endmodule

// File: tb/sim_phy_tune_sequencer.sv
`timescale 1ns/1ps
module sim_phy_tune_sequencer;
    localparam int P = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_phy = '0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [3:0]  req_len = '0;
    logic        req_zero_first = 1'b0;
    logic        done;
    logic [31:0] ctrl_reg;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    logic [31:0] model = '0;
    logic [31:0] prev_ctrl = '0;
    logic        prev_done = 1'b0;
    string       tag = "R1";

    always #2.5 clk = ~clk;

    phy_tune_sequencer #(.PHASE_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_phy(req_phy), .req_addr(req_addr), .req_data(req_data),
        .req_len(req_len), .req_zero_first(req_zero_first),
        .done(done), .ctrl_reg(ctrl_reg)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Monitor: every change of the register must match the next expected write.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ctrl_reg !== prev_ctrl) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {tag, " unexpected write"}, ctrl_reg, prev_ctrl);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(ctrl_reg === e, {tag, " R4 R5 R6 write value"}, ctrl_reg, e);
                end
            end
            if (done && prev_done) check(1'b0, "R10 done longer than one cycle", 32'(done), 0);
            prev_ctrl = ctrl_reg;
            prev_done = done;
        end
    end

    task automatic push(input logic [31:0] v);
        if (v !== model) begin
            exp_q.push_back(v);
            model = v;
        end
    endtask

    task automatic run_req(input logic [1:0] phy, input logic [7:0] addr, input logic [7:0] data,
                           input logic [3:0] len, input bit zero, input bit intrude, input string t);
        int eff;
        int steps;
        int n;
        logic [7:0] a;
        logic [7:0] d;
        logic [31:0] v;
        eff = (len > 8) ? 8 : int'(len);
        steps = (eff == 0) ? 0 : ((zero ? 1 : 0) + 4 * eff);
        tag = t;
        if (eff != 0) begin
            if (zero) push('0);
            a = addr;
            d = data;
            for (int i = 0; i < eff; i++) begin
                v = model; v[15:8] = a; push(v);
                v[7] = d[0]; v[2*phy] = 1'b0; push(v);
                v[2*phy] = 1'b1; push(v);
                v[2*phy] = 1'b0; push(v);
                a = a + 8'd1;
                d = d >> 1;
            end
        end
        @(negedge clk);
        check(req_ready === 1'b1, {t, " R2 ready when idle"}, 32'(req_ready), 1);
        req_valid = 1'b1; req_phy = phy; req_addr = addr; req_data = data;
        req_len = len; req_zero_first = zero;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        check(req_ready === 1'b0, {t, " R2 busy after accept"}, 32'(req_ready), 0);
        if (intrude) begin
            req_valid = 1'b1; req_phy = ~phy; req_addr = 8'hEE; req_data = 8'hFF;
            req_len = 4'd8; req_zero_first = 1'b1;
        end
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
            if (intrude && n == 6) req_valid = 1'b0;
            if (intrude && n < 6) check(req_ready === 1'b0, {t, " R2 refused while busy"}, 32'(req_ready), 0);
        end
        req_valid = 1'b0;
        check(n == steps * P + 1, {t, " R7 done latency"}, n, steps * P + 1);
        #1;
        check(exp_q.size() == 0, {t, " R6 all writes seen"}, exp_q.size(), 0);
        @(negedge clk);
        check(done === 1'b0, {t, " R10 done single cycle"}, 32'(done), 0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ctrl_reg === 32'h0, "R1 register after reset", ctrl_reg, 0);
        check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        check(done === 1'b0, "R1 done after reset", 32'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_req(2'd0, 8'h0c, 8'h01, 4'd1, 1'b0, 1'b0, "R6 one-bit lane0");
        run_req(2'd1, 8'h20, 8'h14, 4'd5, 1'b0, 1'b0, "R5 five-bit lane1");
        run_req(2'd2, 8'h2a, 8'h03, 4'd2, 1'b1, 1'b0, "R3 zero-first lane2");
        run_req(2'd3, 8'h3c, 8'h02, 4'd2, 1'b0, 1'b1, "R2 intrude lane3");
        run_req(2'd1, 8'h55, 8'h99, 4'd0, 1'b0, 1'b0, "R8 zero length");
        check(ctrl_reg === model, "R8 register untouched", ctrl_reg, model);
        run_req(2'd2, 8'hFE, 8'hA5, 4'd12, 1'b0, 1'b0, "R9 clamp and R4 wrap");
        run_req(2'd0, 8'h10, 8'h5A, 4'd8, 1'b1, 1'b0, "R3 zero-first full");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule